// File: doc/BRIEF.md
# Two-Port Clocked Byte-Lane Memory

This block is a synchronous random-access memory with two ports, left and right, that share one word array of 16-bit words. Each port has its own clock, reset, address, write data, read data and controls, and either port can reach any word at any time, including the word the other port is using in the same cycle. Address, write data and every control except the output-off line are registered on the rising edge of the port's clock.

A port is selected by a pair of chip selects, one active low and one active high. A read/write line picks the access direction, and two active-low lane selects pick the upper and lower byte of the word. Those lane selects apply to writes as well as to reads. The pins would be tri-stated on a chip boundary. Here each port instead returns a read-data bus together with a two-bit lane-drive mask; any lane the mask leaves off reads as zero. An asynchronous output-off input forces the mask to zero at once.

A mode input on each port selects flow-through or pipelined output. In flow-through mode, read data is valid in the cycle after the edge that sampled the address. Pipelined mode adds one more output register stage, and the chip selects and the read/write line pass through that extra stage too. The lane selects always go through a single stage. Within the array, each byte has one storage bank per port and a one-bit owner record per port. This lets each port write only storage that it owns. When both ports write the same byte on coinciding edges, the left port's data is the one stored.

Top module: `dpram_tdp`

## Requirements
- R1: A port is selected only when `cs_n_x` is 0 and `cs_x` is 1. Any other combination stores nothing and, in flow-through mode, leaves `rlane_x` at 2'b00 in the following cycle.
- R2: On a selected edge with `read_x` = 0, bits 15:8 are written when `hi_n_x` is 0 and bits 7:0 are written when `lo_n_x` is 0. A lane whose select is 1 keeps its old contents.
- R3: On a selected edge with `read_x` = 1 and `drv_off_x` = 0, `rlane_x[1]` (upper lane, bits 15:8) is set only if `hi_n_x` was 0, and `rlane_x[0]` (lower lane, bits 7:0) is set only if `lo_n_x` was 0. `rdata_x` bits of an undriven lane are 0. A write cycle drives no lane.
- R4: With both lane selects at 1, a selected edge changes no storage and drives no lane.
- R5: While `drv_off_x` is 1, `rlane_x` is 2'b00 and `rdata_x` is 0, without waiting for a clock edge.
- R6: With `pipe_x` = 0, a read sampled at edge k presents its data from edge k until edge k+1.
- R7: With `pipe_x` = 1, a read sampled at edge k presents its data from edge k+1 until edge k+2.
- R8: In pipelined mode the selection and the read/write line take two stages. A read at edge k followed by a deselect at edge k+1 still drives after edge k+1 and stops driving after edge k+2. In flow-through mode a deselect takes effect after one edge.
- R9: In both modes the lane selects take one stage. In pipelined mode the lanes driven after edge k+1 are the ones sampled at edge k+1.
- R10: Both ports may write the same word on coinciding edges. For a lane that both write, the left port's data is stored. Lanes written by only one port take that port's data.
- R11: A read on one port at the same edge as a write to the same word on the other port returns the previous contents. A read at a later edge returns the new contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_l | input | 1 | Left port clock |
| rst_l_n | input | 1 | Left output-path reset, asynchronous, active low |
| pipe_l | input | 1 | Left output mode: 0 flow-through, 1 pipelined |
| cs_n_l | input | 1 | Left chip select, active low |
| cs_l | input | 1 | Left chip select, active high |
| read_l | input | 1 | Left direction: 1 read, 0 write |
| hi_n_l | input | 1 | Left upper-lane select, active low |
| lo_n_l | input | 1 | Left lower-lane select, active low |
| drv_off_l | input | 1 | Left asynchronous output off |
| addr_l | input | ADDR_W | Left word address |
| wdata_l | input | 16 | Left write data |
| rdata_l | output | 16 | Left read data, undriven lanes zero |
| rlane_l | output | 2 | Left lane-drive mask, bit 1 upper, bit 0 lower |
| clk_r | input | 1 | Right port clock |
| rst_r_n | input | 1 | Right output-path reset, asynchronous, active low |
| pipe_r | input | 1 | Right output mode: 0 flow-through, 1 pipelined |
| cs_n_r | input | 1 | Right chip select, active low |
| cs_r | input | 1 | Right chip select, active high |
| read_r | input | 1 | Right direction: 1 read, 0 write |
| hi_n_r | input | 1 | Right upper-lane select, active low |
| lo_n_r | input | 1 | Right lower-lane select, active low |
| drv_off_r | input | 1 | Right asynchronous output off |
| addr_r | input | ADDR_W | Right word address |
| wdata_r | input | 16 | Right write data |
| rdata_r | output | 16 | Right read data, undriven lanes zero |
| rlane_r | output | 2 | Right lane-drive mask, bit 1 upper, bit 0 lower |

## Verification
The bench writes the same byte from both ports on one edge. A design that let the right port win, or that mixed the two values, would return the wrong byte on the read-back. In pipelined mode, the bench deselects on the edge right after a read and also changes the lane selects between two back-to-back reads. A design that buffered the chip selects only once, or that passed the lane selects through two stages, would drive the wrong lanes in the middle cycle. The bench also reads a word from one port while the other port writes it, which exposes a design that forwards the new data. Finally, it raises the output-off line in the middle of a cycle to catch a design that only looks at that line on a clock edge.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
    localparam int LANES  = 2;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;

    typedef enum logic {
        MODE_FLOW = 1'b0,
        MODE_PIPE = 1'b1
    } out_mode_e;

    // decoded per-edge request of one port
    typedef struct packed {
        logic             sel;   // both chip selects active
        logic             rd;    // direction line high
        logic [LANES-1:0] lane;  // lane enables, bit 1 upper
    } port_ctl_t;
endpackage

// File: rtl/dpram_req_decode.sv
module dpram_req_decode
    import dpram_pkg::*;
(
    input  logic             cs_n,
    input  logic             cs,
    input  logic             read,
    input  logic             hi_n,
    input  logic             lo_n,
    output port_ctl_t        ctl,
    output logic [LANES-1:0] wr_lane
);
    always_comb begin
        ctl.sel  = !cs_n && cs;
        ctl.rd   = read;
        ctl.lane = {!hi_n, !lo_n};
        wr_lane  = (ctl.sel && !read) ? ctl.lane : '0;
    end
endmodule

// File: rtl/dpram_lane_store.sv
// One byte lane of the array: a bank and an owner bit per port, so each
// port's clock only ever writes storage of its own.
module dpram_lane_store #(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 8
) (
    input  logic              clk_l,
    input  logic              we_l,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic [LANE_W-1:0] wdata_l,
    output logic [LANE_W-1:0] rdata_l,
    input  logic              clk_r,
    input  logic              we_r,
    input  logic [ADDR_W-1:0] addr_r,
    input  logic [LANE_W-1:0] wdata_r,
    output logic [LANE_W-1:0] rdata_r
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] bank_l [DEPTH];
    logic [LANE_W-1:0] bank_r [DEPTH];
    logic              own_l  [DEPTH];
    logic              own_r  [DEPTH];

    // owner bits differ -> right bank holds the live byte
    logic clash;
    logic we_r_eff;

    assign clash    = we_l && (addr_l == addr_r);
    assign we_r_eff = we_r && !clash;   // left port wins a same-byte collision

    always_ff @(posedge clk_l) begin
        if (we_l) begin
            bank_l[addr_l] <= wdata_l;
            own_l[addr_l]  <= own_r[addr_l];
        end
        rdata_l <= (own_l[addr_l] ^ own_r[addr_l]) ? bank_r[addr_l] : bank_l[addr_l];
    end

    always_ff @(posedge clk_r) begin
        if (we_r_eff) begin
            bank_r[addr_r] <= wdata_r;
            own_r[addr_r]  <= !own_l[addr_r];
        end
        rdata_r <= (own_l[addr_r] ^ own_r[addr_r]) ? bank_r[addr_r] : bank_l[addr_r];
    end
endmodule

// File: rtl/dpram_port_out.sv
module dpram_port_out
    import dpram_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  out_mode_e         mode,
    input  logic              drv_off,
    input  port_ctl_t         ctl,
    input  logic [WORD_W-1:0] arr_q,
    output logic [WORD_W-1:0] rdata,
    output logic [LANES-1:0]  rlane
);
    logic              s1_sel, s1_rd, s2_sel, s2_rd;
    logic [LANES-1:0]  s1_lane;
    logic [WORD_W-1:0] s2_data;
    logic              act_sel, act_rd;
    logic [WORD_W-1:0] act_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_sel  <= 1'b0;
            s1_rd   <= 1'b0;
            s1_lane <= '0;
            s2_sel  <= 1'b0;
            s2_rd   <= 1'b0;
        end else begin
            s1_sel  <= ctl.sel;
            s1_rd   <= ctl.rd;
            s1_lane <= ctl.lane;
            s2_sel  <= s1_sel;
            s2_rd   <= s1_rd;
        end
    end

    always_ff @(posedge clk) begin
        s2_data <= arr_q;
    end

    always_comb begin
        unique case (mode)
            MODE_FLOW: begin
                act_sel  = s1_sel;
                act_rd   = s1_rd;
                act_data = arr_q;
            end
            MODE_PIPE: begin
                act_sel  = s2_sel;
                act_rd   = s2_rd;
                act_data = s2_data;
            end
        endcase
        rlane = (act_sel && act_rd && !drv_off) ? s1_lane : '0;
        for (int i = 0; i < LANES; i++) begin
            rdata[i*LANE_W +: LANE_W] = rlane[i] ? act_data[i*LANE_W +: LANE_W] : '0;
        end
    end
endmodule

// File: rtl/dpram_tdp.sv
module dpram_tdp
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk_l,
    input  logic              rst_l_n,
    input  logic              pipe_l,
    input  logic              cs_n_l,
    input  logic              cs_l,
    input  logic              read_l,
    input  logic              hi_n_l,
    input  logic              lo_n_l,
    input  logic              drv_off_l,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic [15:0]       wdata_l,
    output logic [15:0]       rdata_l,
    output logic [1:0]        rlane_l,
    input  logic              clk_r,
    input  logic              rst_r_n,
    input  logic              pipe_r,
    input  logic              cs_n_r,
    input  logic              cs_r,
    input  logic              read_r,
    input  logic              hi_n_r,
    input  logic              lo_n_r,
    input  logic              drv_off_r,
    input  logic [ADDR_W-1:0] addr_r,
    input  logic [15:0]       wdata_r,
    output logic [15:0]       rdata_r,
    output logic [1:0]        rlane_r
);
    port_ctl_t         ctl_l, ctl_r;
    logic [LANES-1:0]  wl_l, wl_r;
    logic [WORD_W-1:0] arr_l, arr_r;

    dpram_req_decode u_dec_l (
        .cs_n(cs_n_l), .cs(cs_l), .read(read_l), .hi_n(hi_n_l), .lo_n(lo_n_l),
        .ctl(ctl_l), .wr_lane(wl_l)
    );

    dpram_req_decode u_dec_r (
        .cs_n(cs_n_r), .cs(cs_r), .read(read_r), .hi_n(hi_n_r), .lo_n(lo_n_r),
        .ctl(ctl_r), .wr_lane(wl_r)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dpram_lane_store #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_store (
            .clk_l   (clk_l),
            .we_l    (wl_l[g]),
            .addr_l  (addr_l),
            .wdata_l (wdata_l[g*LANE_W +: LANE_W]),
            .rdata_l (arr_l[g*LANE_W +: LANE_W]),
            .clk_r   (clk_r),
            .we_r    (wl_r[g]),
            .addr_r  (addr_r),
            .wdata_r (wdata_r[g*LANE_W +: LANE_W]),
            .rdata_r (arr_r[g*LANE_W +: LANE_W])
        );
    end

    dpram_port_out u_out_l (
        .clk(clk_l), .rst_n(rst_l_n), .mode(out_mode_e'(pipe_l)), .drv_off(drv_off_l),
        .ctl(ctl_l), .arr_q(arr_l), .rdata(rdata_l), .rlane(rlane_l)
    );

    dpram_port_out u_out_r (
        .clk(clk_r), .rst_n(rst_r_n), .mode(out_mode_e'(pipe_r)), .drv_off(drv_off_r),
        .ctl(ctl_r), .arr_q(arr_r), .rdata(rdata_r), .rlane(rlane_r)
    );
endmodule

// File: rtl/dpram_port_chk.sv
module dpram_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pipe,
    input logic       cs_n,
    input logic       cs,
    input logic       read,
    input logic       hi_n,
    input logic       lo_n,
    input logic       drv_off,
    input logic [1:0] rlane
);
    p_drv_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        drv_off |-> rlane == 2'b00);

    p_flow_desel_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe && $past(cs_n || !cs)) |-> rlane == 2'b00);

    p_pipe_desel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe && $past(cs_n || !cs, 2)) |-> rlane == 2'b00);

    p_write_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe && $past(!read)) |-> rlane == 2'b00);

    p_no_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hi_n && lo_n) |-> rlane == 2'b00);

    p_hi_lane_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rlane[1] |-> $past(!hi_n));

    p_lo_lane_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rlane[0] |-> $past(!lo_n));
endmodule

bind dpram_tdp dpram_port_chk u_chk_l (
    .clk(clk_l), .rst_n(rst_l_n), .pipe(pipe_l), .cs_n(cs_n_l), .cs(cs_l),
    .read(read_l), .hi_n(hi_n_l), .lo_n(lo_n_l), .drv_off(drv_off_l), .rlane(rlane_l)
);

bind dpram_tdp dpram_port_chk u_chk_r (
    .clk(clk_r), .rst_n(rst_r_n), .pipe(pipe_r), .cs_n(cs_n_r), .cs(cs_r),
    .read(read_r), .hi_n(hi_n_r), .lo_n(lo_n_r), .drv_off(drv_off_r), .rlane(rlane_r)
);

// File: tb/dpram_tdp_tb.sv
module dpram_tdp_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 20-unit period: 50 MHz at 1 ns per unit; both ports share it

    logic [1:0]  cs_n, cs, rd, hi_n, lo_n, off, pipe;
    logic [7:0]  addr [2];
    logic [15:0] wd   [2];
    logic [15:0] q    [2];
    logic [1:0]  lane [2];

    dpram_tdp #(.ADDR_W(8)) u_dut (
        .clk_l(clk), .rst_l_n(rst_n), .pipe_l(pipe[0]), .cs_n_l(cs_n[0]), .cs_l(cs[0]),
        .read_l(rd[0]), .hi_n_l(hi_n[0]), .lo_n_l(lo_n[0]), .drv_off_l(off[0]),
        .addr_l(addr[0]), .wdata_l(wd[0]), .rdata_l(q[0]), .rlane_l(lane[0]),
        .clk_r(clk), .rst_r_n(rst_n), .pipe_r(pipe[1]), .cs_n_r(cs_n[1]), .cs_r(cs[1]),
        .read_r(rd[1]), .hi_n_r(hi_n[1]), .lo_n_r(lo_n[1]), .drv_off_r(off[1]),
        .addr_r(addr[1]), .wdata_r(wd[1]), .rdata_r(q[1]), .rlane_r(lane[1])
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit chk_on = 0;
    string tag = "R1";

    // scoreboard queues, one entry per port per edge
    int          sq_side [$];
    logic [1:0]  sq_en   [$];
    logic [15:0] sq_data [$];
    string       sq_tag  [$];

    // reference model built from the requirements
    logic [15:0] ref_mem [256];
    logic        m1_sel [2], m1_rd [2], m2_sel [2], m2_rd [2];
    logic [1:0]  m1_lane [2];
    logic [15:0] m1_data [2], m2_data [2];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < 2; s++) begin
                m1_sel[s] = 0; m1_rd[s] = 0; m1_lane[s] = 0; m2_sel[s] = 0; m2_rd[s] = 0;
            end
        end else begin
            for (int s = 0; s < 2; s++) begin
                m2_sel[s]  = m1_sel[s];
                m2_rd[s]   = m1_rd[s];
                m2_data[s] = m1_data[s];
                m1_sel[s]  = !cs_n[s] && cs[s];
                m1_rd[s]   = rd[s];
                m1_lane[s] = {!hi_n[s], !lo_n[s]};
                m1_data[s] = ref_mem[addr[s]];   // old contents (R11)
            end
            // right first, then left, so the left value survives (R10)
            for (int s = 1; s >= 0; s--) begin
                if (!cs_n[s] && cs[s] && !rd[s]) begin
                    if (!hi_n[s]) ref_mem[addr[s]][15:8] = wd[s][15:8];
                    if (!lo_n[s]) ref_mem[addr[s]][7:0]  = wd[s][7:0];
                end
            end
            if (chk_on) begin
                for (int s = 0; s < 2; s++) begin
                    logic        act;
                    logic [1:0]  en;
                    logic [15:0] d;
                    act = pipe[s] ? (m2_sel[s] && m2_rd[s]) : (m1_sel[s] && m1_rd[s]);
                    en  = (act && !off[s]) ? m1_lane[s] : 2'b00;
                    d   = pipe[s] ? m2_data[s] : m1_data[s];
                    d   = {en[1] ? d[15:8] : 8'h00, en[0] ? d[7:0] : 8'h00};
                    sq_side.push_back(s);
                    sq_en.push_back(en);
                    sq_data.push_back(d);
                    sq_tag.push_back(tag);
                end
            end
        end
    end

    // monitor: compare a quarter period after the edge
    always @(posedge clk) begin
        #5;
        while (sq_side.size() > 0) begin
            int          s;
            logic [1:0]  e_en;
            logic [15:0] e_d;
            string       t;
            s    = sq_side.pop_front();
            e_en = sq_en.pop_front();
            e_d  = sq_data.pop_front();
            t    = sq_tag.pop_front();
            checks++;
            if (lane[s] !== e_en || q[s] !== e_d) begin
                failures++;
                $display("FAIL %s port%0d lane=%b data=%h expected lane=%b data=%h",
                         t, s, lane[s], q[s], e_en, e_d);
            end
        end
    end

    task automatic put(input int s, input bit en, input bit rd_i, input bit [1:0] ln,
                       input logic [7:0] a, input logic [15:0] d);
        cs_n[s] = !en; cs[s] = 1'b1; rd[s] = rd_i;
        hi_n[s] = ln[1]; lo_n[s] = ln[0]; addr[s] = a; wd[s] = d;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic direct(input string t, input int s, input logic [1:0] e_en);
        checks++;
        if (lane[s] !== e_en) begin
            failures++;
            $display("FAIL %s port%0d lane=%b expected lane=%b", t, s, lane[s], e_en);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        pipe = 2'b00; off = 2'b00;
        put(0, 0, 1, 2'b11, 0, 0);
        put(1, 0, 1, 2'b11, 0, 0);
        repeat (3) tick();
        direct("R1 reset", 0, 2'b00);
        direct("R1 reset", 1, 2'b00);
        rst_n = 1'b1;
        chk_on = 1'b1;

        // R2: fill the array, both lanes, both ports
        tag = "R2";
        for (int i = 0; i < 128; i++) begin
            put(0, 1, 0, 2'b00, 8'(i),       {8'(i) ^ 8'h3C, 8'(i)});
            put(1, 1, 0, 2'b00, 8'(i + 128), {8'(i + 128) ^ 8'h3C, 8'(i + 128)});
            tick();
        end

        // R6: flow-through reads, back to back
        tag = "R6";
        for (int i = 0; i < 8; i++) begin
            put(0, 1, 1, 2'b00, 8'(i * 3), 0);
            put(1, 1, 1, 2'b00, 8'(200 + i), 0);
            tick();
        end

        // R2: single-lane writes
        tag = "R2";
        put(0, 1, 0, 2'b01, 8'd10, 16'hC3C3);   // upper only
        put(1, 1, 0, 2'b10, 8'd11, 16'h5A5A);   // lower only
        tick();
        // R4: both lane selects high, write and read
        tag = "R4";
        put(0, 1, 0, 2'b11, 8'd12, 16'hFFFF);
        put(1, 1, 1, 2'b11, 8'd13, 0);
        tick();
        // R3: read lane combinations and a quiet write cycle
        tag = "R3";
        put(0, 1, 1, 2'b00, 8'd10, 0);
        put(1, 1, 1, 2'b01, 8'd11, 0);
        tick();
        put(0, 1, 1, 2'b10, 8'd11, 0);
        put(1, 1, 0, 2'b00, 8'd50, 16'h0F0F);
        tick();
        put(0, 1, 1, 2'b00, 8'd12, 0);
        put(1, 1, 1, 2'b00, 8'd50, 0);
        tick();

        // R1: deselect by each chip select, flow mode
        tag = "R1";
        put(0, 0, 1, 2'b00, 8'd1, 0);
        cs_n[1] = 1'b0; cs[1] = 1'b0; rd[1] = 1'b1; hi_n[1] = 1'b0; lo_n[1] = 1'b0;
        tick();
        cs_n[0] = 1'b0; cs[0] = 1'b0; rd[0] = 1'b0;   // deselected write must not store
        addr[0] = 8'd2; wd[0] = 16'hDEAD;
        put(1, 1, 1, 2'b00, 8'd3, 0);
        tick();
        put(0, 1, 1, 2'b00, 8'd2, 0);
        put(1, 0, 1, 2'b00, 8'd3, 0);
        tick();

        // R5: output-off held through an edge, then raised mid-cycle
        tag = "R5";
        off[0] = 1'b1;
        put(0, 1, 1, 2'b00, 8'd4, 0);
        tick();
        off[0] = 1'b0;
        put(1, 1, 1, 2'b00, 8'd5, 0);
        tick();
        #2 off[1] = 1'b1;
        #2 direct("R5 async off", 1, 2'b00);
        off[1] = 1'b0;
        #1 direct("R5 async on", 1, 2'b11);
        put(0, 0, 1, 2'b00, 0, 0);
        put(1, 0, 1, 2'b00, 0, 0);
        tick();

        // R7: pipelined latency
        tag = "R7";
        pipe = 2'b11;
        for (int i = 0; i < 6; i++) begin
            put(0, 1, 1, 2'b00, 8'(60 + i), 0);
            put(1, 1, 1, 2'b00, 8'(140 + i), 0);
            tick();
        end
        // R8: read, then deselect, two-cycle deselect
        tag = "R8";
        put(0, 1, 1, 2'b00, 8'd70, 0);
        put(1, 1, 1, 2'b00, 8'd71, 0);
        tick();
        put(0, 0, 1, 2'b00, 8'd72, 0);
        cs_n[1] = 1'b0; cs[1] = 1'b0;
        tick();
        put(0, 0, 1, 2'b00, 0, 0);
        put(1, 0, 1, 2'b00, 0, 0);
        tick();
        tick();
        // R9: lane selects change between reads in pipelined mode
        tag = "R9";
        put(0, 1, 1, 2'b00, 8'd80, 0);
        put(1, 1, 1, 2'b10, 8'd81, 0);
        tick();
        put(0, 1, 1, 2'b01, 8'd82, 0);
        put(1, 1, 1, 2'b00, 8'd83, 0);
        tick();
        put(0, 0, 1, 2'b00, 0, 0);
        put(1, 0, 1, 2'b11, 0, 0);
        tick();
        tick();
        pipe = 2'b00;
        tick();

        // R10: coinciding writes to one word
        tag = "R10";
        put(0, 1, 0, 2'b00, 8'd30, 16'hAAAA);
        put(1, 1, 0, 2'b00, 8'd30, 16'h5555);
        tick();
        put(0, 1, 0, 2'b01, 8'd31, 16'h1234);
        put(1, 1, 0, 2'b00, 8'd31, 16'h5678);
        tick();
        put(0, 1, 1, 2'b00, 8'd30, 0);
        put(1, 1, 1, 2'b00, 8'd31, 0);
        tick();
        put(1, 1, 1, 2'b00, 8'd30, 0);
        put(0, 1, 1, 2'b00, 8'd31, 0);
        tick();

        // R11: read while the other port writes the same word
        tag = "R11";
        put(0, 1, 1, 2'b00, 8'd40, 0);
        put(1, 1, 0, 2'b00, 8'd40, 16'hBEEF);
        tick();
        put(0, 1, 1, 2'b00, 8'd40, 0);
        put(1, 1, 1, 2'b00, 8'd41, 0);
        tick();
        put(1, 1, 1, 2'b00, 8'd30, 0);
        put(0, 1, 0, 2'b00, 8'd30, 16'h7777);
        tick();
        put(1, 1, 1, 2'b00, 8'd30, 0);
        put(0, 0, 1, 2'b00, 0, 0);
        tick();

        put(0, 0, 1, 2'b00, 0, 0);
        put(1, 0, 1, 2'b00, 0, 0);
        repeat (4) tick();
        done = 1'b1;
        summary();
        $finish;
    end
endmodule